// File: doc/BRIEF.md
# Pad Attribute Register File with Lock

The block keeps one 6-bit attribute word for every chip pad and presents all of them to the pad ring as packed vectors indexed by pad number. It has two independent arrays: one for pads that go through the pin multiplexer, and one for pads owned by dedicated peripherals. Software reaches the words over a simple register bus that carries a word address, write data, a write strobe and combinational read data.

In each attribute word, bit 0 inverts both input and output, bit 1 enables open drain, bit 2 a pull-down, bit 3 a pull-up and bit 4 a keeper, and bit 5 selects weak drive (1) over strong drive (0). Word addresses 0 to N_MUX-1 hold the multiplexed pads, the next N_DED addresses hold the dedicated pads, and the address after those holds the lock register. Writing 1 to bit 0 of the lock register freezes the whole configuration until the next reset.

Top module: `pad_attr_regs`

## Requirements
- R1: After reset every attribute word is zero and the lock reads 0 (unlocked).
- R2: A write to address a < N_MUX loads wdata[5:0] into multiplexed pad a, which appears on mux_attr_o[a*6 +: 6] after the next clock edge. No other pad changes.
- R3: A write to address N_MUX+d, with d < N_DED, loads dedicated pad d, which appears on ded_attr_o[d*6 +: 6]. No other pad changes.
- R4: A read returns the stored word zero-extended to the data width. The lock address returns the lock in bit 0.
- R5: Writing 1 in bit 0 of the lock address (N_MUX+N_DED) sets the lock. Writing 0 there has no effect.
- R6: When the lock is set, writes to attribute words are dropped and every stored word stays unchanged.
- R7: Once set, the lock stays set until reset, whatever is written to it.
- R8: A read from an address above the lock address returns zero, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data (combinational) |
| mux_attr_o | output | N_MUX*6 | Attributes of the multiplexed pads, packed by pad |
| ded_attr_o | output | N_DED*6 | Attributes of the dedicated pads, packed by pad |

## Verification
The bench sweeps every address in the map, including several unmapped ones, with patterns that differ per address. After each sweep it compares both packed outputs and every read-back with a model array. This separates a write decoded to the wrong pad or the wrong array from a write that is lost. A second sweep runs after the lock is set and writes the bitwise inverse of every stored word. Any word that changes means the write gate leaks. Writes of 0 and of 1 to the lock before and after locking show that the lock is sticky and that writing 0 leaves it clear.

// File: rtl/pad_attr_pkg.sv
package pad_attr_pkg;
  localparam int unsigned ATTR_W = 6;
  typedef enum logic [1:0] {SEL_MUX, SEL_DED, SEL_LOCK, SEL_NONE} sel_e;
endpackage

// File: rtl/pad_attr_decode.sv
module pad_attr_decode #(
  parameter int unsigned N_MUX = 4,
  parameter int unsigned N_DED = 16,
  parameter int unsigned AW    = 8,
  localparam int unsigned IW   = (N_MUX + N_DED > 1) ? $clog2(N_MUX + N_DED) : 1
) (
  input  logic [AW-1:0]         addr_i,
  output pad_attr_pkg::sel_e    sel_o,
  output logic [IW-1:0]         idx_o
);
  import pad_attr_pkg::*;
  localparam int unsigned LOCK_A = N_MUX + N_DED;

  always_comb begin
    sel_o = SEL_NONE;
    idx_o = '0;
    if (32'(addr_i) < N_MUX) begin
      sel_o = SEL_MUX;
      idx_o = IW'(addr_i);
    end else if (32'(addr_i) < LOCK_A) begin
      sel_o = SEL_DED;
      idx_o = IW'(32'(addr_i) - N_MUX);
    end else if (32'(addr_i) == LOCK_A) begin
      sel_o = SEL_LOCK;
    end
  end
endmodule

// File: rtl/pad_attr_bank.sv
module pad_attr_bank #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 5,
  localparam int unsigned AT = pad_attr_pkg::ATTR_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [AT-1:0]   wdata_i,
  output logic [AT-1:0]   rdata_o,
  output logic [N*AT-1:0] attr_o
);
  logic [AT-1:0] word_q [N];

  for (genvar g = 0; g < N; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         word_q[g] <= '0;
      else if (we_i && 32'(idx_i) == g)    word_q[g] <= wdata_i;
    end
    assign attr_o[g*AT +: AT] = word_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++) if (32'(idx_i) == i) rdata_o = word_q[i];
  end

  // R6: without a strobe the bank holds its contents
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(attr_o));
endmodule

// File: rtl/pad_attr_regs.sv
module pad_attr_regs #(
  parameter int unsigned N_MUX = 4,
  parameter int unsigned N_DED = 16,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned AT   = pad_attr_pkg::ATTR_W,
  localparam int unsigned IW   = (N_MUX + N_DED > 1) ? $clog2(N_MUX + N_DED) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [N_MUX*AT-1:0] mux_attr_o,
  output logic [N_DED*AT-1:0] ded_attr_o
);
  import pad_attr_pkg::*;

  sel_e          sel;
  logic [IW-1:0] idx;
  logic          lock_q;
  logic [AT-1:0] mux_rd, ded_rd;

  pad_attr_decode #(.N_MUX(N_MUX), .N_DED(N_DED), .AW(AW)) u_dec (
    .addr_i(addr_i), .sel_o(sel), .idx_o(idx));

  // writes to either bank are gated by the lock
  logic wr_ok;
  assign wr_ok = we_i && !lock_q;

  pad_attr_bank #(.N(N_MUX), .IW(IW)) u_mux (
    .clk_i, .rst_ni, .we_i(wr_ok && sel == SEL_MUX), .idx_i(idx),
    .wdata_i(wdata_i[AT-1:0]), .rdata_o(mux_rd), .attr_o(mux_attr_o));

  pad_attr_bank #(.N(N_DED), .IW(IW)) u_ded (
    .clk_i, .rst_ni, .we_i(wr_ok && sel == SEL_DED), .idx_i(idx),
    .wdata_i(wdata_i[AT-1:0]), .rdata_o(ded_rd), .attr_o(ded_attr_o));

  // sticky write-one-to-set lock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   lock_q <= 1'b0;
    else if (we_i && sel == SEL_LOCK && wdata_i[0]) lock_q <= 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_MUX:  rdata_o[AT-1:0] = mux_rd;
      SEL_DED:  rdata_o[AT-1:0] = ded_rd;
      SEL_LOCK: rdata_o[0]      = lock_q;
      default:  rdata_o         = '0;
    endcase
  end

  assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  assert_locked_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(mux_attr_o) && $stable(ded_attr_o));
  assert_zero_noset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && !(we_i && wdata_i[0])) |=> !lock_q);
  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) > N_MUX + N_DED) |-> rdata_o == '0);
  assert_rd_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:AT] == '0);
endmodule

// File: tb/test_pad_attr_regs.sv
module test_pad_attr_regs;
  localparam int NM = 4, ND = 16, AW = 8, DW = 32, AT = 6;
  localparam int LOCK_A = NM + ND;

  logic clk = 0, rst_ni = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NM*AT-1:0] mux_attr;
  logic [ND*AT-1:0] ded_attr;
  int checks = 0, errors = 0;
  logic [AT-1:0] model [NM+ND];

  always #2.5 clk = ~clk;

  pad_attr_regs #(.N_MUX(NM), .N_DED(ND), .AW(AW), .DW(DW)) i_pad_attr_regs (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .mux_attr_o(mux_attr), .ded_attr_o(ded_attr));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk); we = 1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(string req, int a, logic [DW-1:0] exp);
    @(negedge clk); addr = AW'(a); #1; chk(req, rdata, exp);
  endtask

  task automatic check_all(string req);
    for (int p = 0; p < NM; p++) chk(req, DW'(mux_attr[p*AT +: AT]), DW'(model[p]));
    for (int p = 0; p < ND; p++) chk(req, DW'(ded_attr[p*AT +: AT]), DW'(model[NM+p]));
    for (int a = 0; a < NM + ND; a++) rd_chk({req, "/R4"}, a, DW'(model[a]));
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NM + ND; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    check_all("R1");
    rd_chk("R1", LOCK_A, 0);
    // R2/R3 sweep: distinct pattern per address, upper bits set to prove truncation
    for (int a = 0; a < NM + ND; a++) begin
      wr(a, 32'hFFFF_FFC0 | DW'((a * 7 + 3) % 64));
      model[a] = AT'((a * 7 + 3) % 64);
    end
    check_all("R2_R3");
    // second pattern, reverse order
    for (int a = NM + ND - 1; a >= 0; a--) begin
      wr(a, DW'(63 - a));
      model[a] = AT'(63 - a);
    end
    check_all("R2_R3");
    // R8 unmapped: reads zero, writes have no effect
    for (int a = LOCK_A + 1; a < LOCK_A + 6; a++) begin
      wr(a, 32'hFFFF_FFFF);
      rd_chk("R8", a, 0);
    end
    rd_chk("R8", 255, 0);
    check_all("R8");
    rd_chk("R8", LOCK_A, 0);
    // R5 writing 0 to lock does nothing
    wr(LOCK_A, 32'hFFFF_FFFE);
    rd_chk("R5", LOCK_A, 0);
    wr(0, DW'(6'h2A)); model[0] = 6'h2A;
    chk("R5", DW'(mux_attr[0 +: AT]), DW'(6'h2A));
    // R5 set lock
    wr(LOCK_A, 1);
    rd_chk("R5", LOCK_A, 1);
    // R6 locked: invert every word, nothing changes
    for (int a = 0; a < NM + ND; a++) wr(a, DW'(~model[a]));
    check_all("R6");
    // R7 lock sticky
    wr(LOCK_A, 0);
    rd_chk("R7", LOCK_A, 1);
    wr(NM, DW'(~model[NM]));
    chk("R7", DW'(ded_attr[0 +: AT]), DW'(model[NM]));
    // R1 reset clears everything again
    @(negedge clk); rst_ni = 0; @(negedge clk); rst_ni = 1;
    for (int i = 0; i < NM + ND; i++) model[i] = '0;
    check_all("R1");
    rd_chk("R1", LOCK_A, 0);
    wr(NM + ND - 1, DW'(6'h15)); model[NM+ND-1] = 6'h15;
    check_all("R3");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule